// File: doc/BRIEF.md
# Two-Channel Ordered Break Sequencer

This block merges the match pulses of two break-condition channels, A and B, into a single user-break request. The address and data comparators sit upstream and are not part of the block. Each channel delivers a one-cycle match pulse. A channel may watch the main data bus, the instruction bus, or either of the two local memory buses.

When the ordering-mode input is high, a break needs a strict order: channel A must match first, which arms the block, and channel B must match afterwards. A programmable execution count sets how many channel B matches are needed once A is armed. When the ordering-mode input is low, a match on either channel raises the break request directly.

The break request is a registered one-cycle pulse. The armed state of channel A is brought out so that software or a debugger can see a half-completed sequence.

Top module: `seq_break_top`

## Requirements
- R1: After reset, `brk_req_o` and `a_armed_o` are 0 and the programmed count is 1.
- R2: With `seq_mode_i` = 0, a cycle with `match_a_i` or `match_b_i` high gives `brk_req_o` = 1 for exactly the next cycle, and `a_armed_o` stays 0.
- R3: With `seq_mode_i` = 1 and the block not armed, a cycle with `match_a_i` = 1 and `match_b_i` = 0 sets `a_armed_o` in the next cycle and raises no break.
- R4: With `seq_mode_i` = 1 and the block not armed, a `match_b_i` pulse raises no break and leaves no trace: a later A-then-B order still needs the full count.
- R5: With `seq_mode_i` = 1 and the block not armed, `match_a_i` and `match_b_i` high in the same cycle neither arm the block nor raise a break.
- R6: While armed with a remaining count of 1, a `match_b_i` pulse gives `brk_req_o` = 1 in the next cycle, and `a_armed_o` falls in that same cycle.
- R7: Arming loads the remaining count from the programmed value. Each B match while armed either lowers the remaining count by one or, when the remaining count is 1 or 0, fires the break. So a programmed value of N (N ≥ 1) breaks on the Nth B match, and 0 behaves like 1.
- R8: A `match_a_i` pulse while already armed keeps `a_armed_o` high and does not reload the remaining count.
- R9: A cycle with `seq_mode_i` = 0 clears `a_armed_o` in the next cycle, so a pending A match is discarded.
- R10: `cnt_load_i` = 1 stores `cnt_value_i` as the programmed count. The new value applies from the next arming, including an arming in the same cycle. It does not change the remaining count of a sequence already armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_mode_i | input | 1 | 1 = ordered A-then-B mode, 0 = independent channels |
| match_a_i | input | 1 | Channel A match pulse |
| match_b_i | input | 1 | Channel B match pulse |
| cnt_load_i | input | 1 | Store `cnt_value_i` as the programmed execution count |
| cnt_value_i | input | CNT_W | Execution count value |
| brk_req_o | output | 1 | One-cycle user-break request |
| a_armed_o | output | 1 | Channel A has matched and is waiting for B |

## Verification
Every result of the block is registered once. The break pulse, the armed flag and the remaining count all reflect the inputs of clock edge k during the cycle after that edge. The bench drives inputs on falling edges. A behavioural reference model advances on each rising edge using the inputs seen there. Both outputs are compared against the model on the following falling edge, so every comparison sits exactly one edge after its stimulus. Directed phases cover each ordering and count corner and tag the comparisons with the matching requirement. A long random phase then mixes mode changes, loads and simultaneous matches.

// File: rtl/seq_break_pkg.sv
package seq_break_pkg;

  typedef struct packed {
    logic a;
    logic b;
  } match_pair_t;

  // Independent-channel request: either channel alone suffices.
  function automatic logic direct_hit(match_pair_t m);
    return m.a | m.b;
  endfunction

  // A match that may arm the sequencer: A without B in the same cycle.
  function automatic logic lone_a(match_pair_t m);
    return m.a & ~m.b;
  endfunction

endpackage

// File: rtl/sb_exec_counter.sv
module sb_exec_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] value_i,
  input  logic             restart_i,
  input  logic             step_i,
  output logic             last_o,
  output logic [CNT_W-1:0] rem_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] prog_q;
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] reload_val;

  // Zero and one both mean "this B match is the last one needed".
  function automatic logic is_last(logic [CNT_W-1:0] v);
    return v <= ONE;
  endfunction

  function automatic logic [CNT_W-1:0] count_down(logic [CNT_W-1:0] v);
    return v - ONE;
  endfunction

  // A load in the arming cycle takes effect immediately.
  assign reload_val = load_i ? value_i : prog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= ONE;
    end else if (load_i) begin
      prog_q <= value_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= ONE;
    end else if (restart_i) begin
      rem_q <= reload_val;
    end else if (step_i) begin
      rem_q <= count_down(rem_q);
    end
  end

  assign last_o = is_last(rem_q);
  assign rem_o  = rem_q;

endmodule

// File: rtl/sb_arm_flag.sv
module sb_arm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_mode_i,
  input  logic set_i,
  input  logic clear_i,
  output logic armed_o
);

  logic armed_q;
  logic armed_d;

  always_comb begin
    if (!seq_mode_i) begin
      armed_d = 1'b0;
    end else begin
      armed_d = (armed_q | set_i) & ~clear_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
    end
  end

  assign armed_o = armed_q;

endmodule

// File: rtl/sb_break_gen.sv
module sb_break_gen
  import seq_break_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seq_mode_i,
  input  match_pair_t match_i,
  input  logic        armed_i,
  input  logic        last_i,
  output logic        fire_seq_o,
  output logic        brk_o
);

  logic fire_direct;
  logic brk_q;

  assign fire_seq_o  = seq_mode_i & armed_i & match_i.b & last_i;
  assign fire_direct = ~seq_mode_i & direct_hit(match_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q <= 1'b0;
    end else begin
      brk_q <= fire_seq_o | fire_direct;
    end
  end

  assign brk_o = brk_q;

endmodule

// File: rtl/seq_break_top.sv
module seq_break_top
  import seq_break_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_mode_i,
  input  logic             match_a_i,
  input  logic             match_b_i,
  input  logic             cnt_load_i,
  input  logic [CNT_W-1:0] cnt_value_i,
  output logic             brk_req_o,
  output logic             a_armed_o
);

  match_pair_t      match;
  logic             armed;
  logic             arm_set;
  logic             b_qual;
  logic             cnt_last;
  logic             cnt_step;
  logic             fire_seq;
  logic [CNT_W-1:0] cnt_rem;

  assign match.a = match_a_i;
  assign match.b = match_b_i;

  // Named internal events.
  assign arm_set  = seq_mode_i & ~armed & lone_a(match);
  assign b_qual   = seq_mode_i & armed & match_b_i;
  assign cnt_step = b_qual & ~cnt_last;

  sb_arm_flag u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .seq_mode_i (seq_mode_i),
    .set_i      (arm_set),
    .clear_i    (fire_seq),
    .armed_o    (armed)
  );

  sb_exec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (cnt_load_i),
    .value_i   (cnt_value_i),
    .restart_i (arm_set),
    .step_i    (cnt_step),
    .last_o    (cnt_last),
    .rem_o     (cnt_rem)
  );

  sb_break_gen u_brk (
    .clk        (clk),
    .rst_n      (rst_n),
    .seq_mode_i (seq_mode_i),
    .match_i    (match),
    .armed_i    (armed),
    .last_i     (cnt_last),
    .fire_seq_o (fire_seq),
    .brk_o      (brk_req_o)
  );

  assign a_armed_o = armed;

endmodule

// File: rtl/seq_break_checker.sv
module seq_break_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             seq_mode_i,
  input logic             match_a_i,
  input logic             match_b_i,
  input logic             brk_req_o,
  input logic             a_armed_o,
  input logic [CNT_W-1:0] cnt_rem
);

  assert_direct_break_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_mode_i && (match_a_i || match_b_i)) |=> brk_req_o);

  assert_mode_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_mode_i |=> !a_armed_o);

  assert_arm_on_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode_i && !a_armed_o && match_a_i && !match_b_i) |=> (a_armed_o && !brk_req_o));

  assert_early_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode_i && !a_armed_o && match_b_i) |=> !brk_req_o);

  assert_same_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode_i && !a_armed_o && match_a_i && match_b_i) |=> !a_armed_o);

  assert_disarm_on_break_R6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req_o |-> !a_armed_o);

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode_i && a_armed_o && !match_b_i) |=> (a_armed_o && $stable(cnt_rem)));

endmodule

bind seq_break_top seq_break_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .seq_mode_i (seq_mode_i),
  .match_a_i  (match_a_i),
  .match_b_i  (match_b_i),
  .brk_req_o  (brk_req_o),
  .a_armed_o  (a_armed_o),
  .cnt_rem    (cnt_rem)
);

// File: tb/seq_break_top_tb_top.sv
module seq_break_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int WATCHDOG = 100000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             seq_mode_i = 1'b0;
  logic             match_a_i = 1'b0;
  logic             match_b_i = 1'b0;
  logic             cnt_load_i = 1'b0;
  logic [CNT_W-1:0] cnt_value_i = '0;
  logic             brk_req_o;
  logic             a_armed_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  // Reference model state.
  int  m_rem = 1;
  int  m_prog = 1;
  bit  m_armed = 0;
  bit  m_brk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_break_top #(.CNT_W(CNT_W)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .seq_mode_i  (seq_mode_i),
    .match_a_i   (match_a_i),
    .match_b_i   (match_b_i),
    .cnt_load_i  (cnt_load_i),
    .cnt_value_i (cnt_value_i),
    .brk_req_o   (brk_req_o),
    .a_armed_o   (a_armed_o)
  );

  // Behavioural reference, written from the requirements.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rem = 1; m_prog = 1; m_armed = 0; m_brk = 0;
    end else begin
      m_brk = 0;
      if (!seq_mode_i) begin
        m_brk = match_a_i || match_b_i;
        m_armed = 0;
      end else if (m_armed && match_b_i) begin
        if (m_rem <= 1) begin
          m_brk = 1;
          m_armed = 0;
        end else begin
          m_rem = m_rem - 1;
        end
      end else if (!m_armed && match_a_i && !match_b_i) begin
        m_armed = 1;
        m_rem = cnt_load_i ? int'(cnt_value_i) : m_prog;
      end
      if (cnt_load_i) m_prog = int'(cnt_value_i);
    end
  end

  // Compare on every falling edge after reset.
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (brk_req_o !== m_brk || a_armed_o !== m_armed) begin
        errors++;
        $display("FAIL %s at cycle %0d: brk=%b armed=%b expected brk=%b armed=%b",
                 cur_req, cycles, brk_req_o, a_armed_o, m_brk, m_armed);
      end
    end
  end

  task automatic drive(input bit seq, input bit a, input bit b,
                       input bit ld = 0, input int val = 0);
    @(negedge clk);
    seq_mode_i  = seq;
    match_a_i   = a;
    match_b_i   = b;
    cnt_load_i  = ld;
    cnt_value_i = CNT_W'(val);
  endtask

  task automatic idle(input bit seq, input int n);
    for (int i = 0; i < n; i++) drive(seq, 0, 0);
  endtask

  // Directed check on an explicit expected value, independent of the model.
  task automatic expect_out(input string req, input bit brk, input bit armed);
    @(negedge clk);
    checks++;
    if (brk_req_o !== brk || a_armed_o !== armed) begin
      errors++;
      $display("FAIL %s: brk=%b armed=%b expected brk=%b armed=%b",
               req, brk_req_o, a_armed_o, brk, armed);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d: done=0 expected done=1", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    checks++;
    if (brk_req_o !== 1'b0 || a_armed_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: brk=%b armed=%b expected brk=0 armed=0", brk_req_o, a_armed_o);
    end
    rst_n = 1'b1;
    idle(1, 2);

    // R2: independent channels
    cur_req = "R2";
    drive(0, 1, 0); drive(0, 0, 0);
    drive(0, 0, 1); drive(0, 0, 0);
    drive(0, 1, 1); drive(0, 0, 0);
    idle(0, 2);

    // R3 / R6: A then B with default count 1
    cur_req = "R3";
    drive(1, 1, 0); drive(1, 0, 0);
    idle(1, 2);
    cur_req = "R6";
    drive(1, 0, 1); drive(1, 0, 0);
    idle(1, 2);

    // R4: B first is forgotten
    cur_req = "R4";
    drive(1, 0, 1, 1, 2); drive(1, 0, 0);
    drive(1, 1, 0); drive(1, 0, 1); drive(1, 0, 0);
    drive(1, 0, 1); drive(1, 0, 0);
    idle(1, 2);

    // R5: simultaneous A and B while idle
    cur_req = "R5";
    drive(1, 1, 1, 1, 1); drive(1, 0, 0);
    drive(1, 0, 1); drive(1, 0, 0);
    idle(1, 2);

    // R7: count of 3, then count of 0
    cur_req = "R7";
    drive(1, 0, 0, 1, 3);
    drive(1, 1, 0);
    drive(1, 0, 1); drive(1, 0, 1); drive(1, 0, 1);
    idle(1, 2);
    drive(1, 0, 0, 1, 0);
    drive(1, 1, 0); drive(1, 0, 1);
    idle(1, 2);

    // R8: repeated A does not restart
    cur_req = "R8";
    drive(1, 0, 0, 1, 2);
    drive(1, 1, 0); drive(1, 0, 1); drive(1, 1, 0); drive(1, 1, 0);
    drive(1, 0, 1);
    idle(1, 2);

    // R9: mode clear discards pending A
    cur_req = "R9";
    drive(1, 0, 0, 1, 1);
    drive(1, 1, 0); drive(0, 0, 0); drive(1, 0, 0);
    drive(1, 0, 1); drive(1, 0, 0);
    idle(1, 2);

    // R10: load during a sequence only affects the next arming
    cur_req = "R10";
    drive(1, 0, 0, 1, 2);
    drive(1, 1, 0); drive(1, 0, 0, 1, 1);
    drive(1, 0, 1); drive(1, 0, 1);
    idle(1, 2);
    drive(1, 1, 0, 1, 3);
    drive(1, 0, 1); drive(1, 0, 1); drive(1, 0, 1);
    idle(1, 2);

    // Explicit directed checks with hand-computed values
    drive(1, 0, 0, 1, 1);
    drive(1, 1, 0);
    expect_out("R3", 0, 1);
    match_a_i = 0; match_b_i = 1;
    expect_out("R6", 1, 0);
    match_b_i = 0;
    drive(0, 0, 1);
    expect_out("R2", 1, 0);
    match_b_i = 0;
    drive(1, 1, 1);
    expect_out("R5", 0, 0);
    match_a_i = 0; match_b_i = 0;
    drive(1, 0, 1);
    expect_out("R4", 0, 0);
    match_b_i = 0;
    drive(1, 1, 0);
    expect_out("R3", 0, 1);
    seq_mode_i = 0; match_a_i = 0;
    expect_out("R9", 0, 0);
    idle(1, 2);

    // Random mix
    cur_req = "R7";
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 16) != 0, ($urandom % 4) == 0, ($urandom % 3) == 0,
            ($urandom % 20) == 0, int'($urandom % 4));
    end
    idle(1, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule